// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a link to an 8-bit converter that has a serial output. The converter is reached over three wires: an active-low conversion-start line driven by the block, a serial clock driven by the block, and a data line driven by the converter. A one-cycle start request sent while the block is idle runs one full transaction. The block lowers the conversion-start line for a short pulse and then waits a fixed number of system clocks. During that wait the serial clock stays at its idle level, because the converter ignores the clock while it converts. Once the wait has elapsed, the first result bit is already on the data line, and the block takes it before the clock moves.

The block then produces eight serial clock pulses. The converter moves its data line on every falling edge of the serial clock, and the block samples on the rising edge that follows, half a period later. It keeps sampling until seven more bits have been collected. It takes no bit after that, because the converter lets go of the line after the last rising edge. The assembled byte appears on the result output together with a one-cycle done strobe. A configuration input selects whether the serial clock rests low or high between transactions. The wait length, the half period of the serial clock, the width of the start pulse and the number of bits are all parameters counted in system clocks or bits.

Top module: `adc_rd_top`

## Requirements
- R1: While reset is held and after it is released, the conversion-start line is high, the serial clock rests at the level chosen by `idleHigh`, `busy` and `doneOut` are low, and `dataOut` is 0.
- R2: A start request that is sampled while the block is idle sets `busy` from the next cycle. In that same cycle the conversion-start line goes low, and it stays low for exactly START_PULSE cycles.
- R3: For the CONV_CYCLES cycles after a request is accepted, and for one more cycle after that, the serial clock does not change and stays at its idle level.
- R4: The most significant result bit is sampled from `sdataIn` on the clock edge CONV_CYCLES+1 cycles after acceptance, which comes before any serial clock transition.
- R5: After that sample, the serial clock toggles exactly 16 times, once every HALF_CYCLES system clocks, and finishes at its idle level. With the default of 13 cycles at 125 MHz, the serial clock period is 208 ns, which keeps it at or below 5 MHz.
- R6: The remaining seven bits are taken from `sdataIn` on serial clock rising edges, counting only those rising edges that come after at least one falling edge. Sampling stops once eight bits are held, so the data line is never read after the eighth rising edge.
- R7: `dataOut` is straight binary, and the first bit received is bit 7. The codes 0x00 and 0xFF both pass through unchanged.
- R8: With `idleHigh`=0 the serial clock rests low and each pulse is a rise followed by a fall. With `idleHigh`=1 it rests high and each pulse is a fall followed by a rise.
- R9: `doneOut` is high for exactly one cycle, CONV_CYCLES+2+16*HALF_CYCLES cycles after acceptance, and `busy` is low in that cycle. `dataOut` holds the new result from that cycle until the next done strobe.
- R10: A start request that arrives while `busy` is high is ignored. The conversion-start line does not fall again, and the transaction in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Request to start one conversion and readout |
| idleHigh | input | 1 | Serial clock rest level: 0 for low, 1 for high |
| sdataIn | input | 1 | Serial data from the converter |
| convStN | output | 1 | Conversion-start line to the converter, active low |
| sclkOut | output | 1 | Serial clock to the converter |
| busy | output | 1 | High while a transaction is running |
| dataOut | output | 8 | Last completed conversion result |
| doneOut | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `idleHigh` does not change while `busy` is high, because the check that the clock has returned to its rest level compares against the current value of that input. They also assume that the converter moves `sdataIn` only on falling edges of the serial clock, so that every sampled bit has had half a period to settle. The stimulus changes `idleHigh` only between transactions. The converter model in the bench moves its data line only when it sees a falling serial clock edge, and it drives the complement of the last bit once it releases the line, so any extra sample shows up in the result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Transaction phases of the read controller
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_MSB,
    ST_CLOCK,
    ST_FINISH
  } rdState_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic park;      // hold serial clock at its rest level
    logic toggle;    // invert the serial clock this cycle
    logic loadMsb;   // capture first bit before any clock edge
    logic shiftBit;  // append data line to the shift register
    logic publish;   // move assembled byte to the output
  } rdStrobe_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CONV_CYCLES = 940,
  parameter int START_PULSE = 4,
  parameter int HALF_CYCLES = 13,
  parameter int DATA_BITS   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      idleHigh,
  input  logic      sclkLevel,
  output rdStrobe_t strb,
  output logic      convStN,
  output logic      busy
);

  localparam int WAIT_W = $clog2(CONV_CYCLES + 1);
  localparam int HALF_W = $clog2(HALF_CYCLES + 1);
  localparam int EDGES  = 2 * DATA_BITS;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam int BIT_W  = $clog2(DATA_BITS + 1);

  rdState_e          state, nextState;
  logic [WAIT_W-1:0] waitCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              fallSeen;
  logic              convLow;
  logic              halfDone;
  logic              wantBit;
  logic              waitOver;
  logic              lastEdge;

  // A half period ends on the last count of the divider
  assign halfDone = (state == ST_CLOCK) && (halfCnt == HALF_W'(HALF_CYCLES - 1));
  assign waitOver = (waitCnt == WAIT_W'(CONV_CYCLES - 1));
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));

  // Sample only on a rising edge that follows a device-side falling edge
  assign wantBit = halfDone && !sclkLevel && fallSeen && (bitCnt < BIT_W'(DATA_BITS));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (startReq) nextState = ST_CONV;
      ST_CONV:   if (waitOver) nextState = ST_MSB;
      ST_MSB:    nextState = ST_CLOCK;
      ST_CLOCK:  if (halfDone && lastEdge) nextState = ST_FINISH;
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.park     = (state != ST_CLOCK);
    strb.toggle   = halfDone;
    strb.loadMsb  = (state == ST_MSB);
    strb.shiftBit = wantBit;
    strb.publish  = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      halfCnt  <= '0;
      edgeCnt  <= '0;
      bitCnt   <= '0;
      fallSeen <= 1'b0;
      convLow  <= 1'b0;
    end else begin
      state <= nextState;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            waitCnt <= '0;
            convLow <= 1'b1;
          end
        end
        ST_CONV: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt == WAIT_W'(START_PULSE - 1)) convLow <= 1'b0;
        end
        ST_MSB: begin
          halfCnt  <= '0;
          edgeCnt  <= '0;
          bitCnt   <= BIT_W'(1);
          fallSeen <= 1'b0;
        end
        ST_CLOCK: begin
          if (halfDone) begin
            halfCnt <= '0;
            edgeCnt <= edgeCnt + 1'b1;
            if (wantBit) bitCnt <= bitCnt + 1'b1;
            if (sclkLevel) fallSeen <= 1'b1;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign convStN = !convLow;

  // R2: the start pulse begins only from a fresh acceptance
  a_r2_pulse_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convLow) |-> (state == ST_CONV) && (waitCnt == '0));

  // R3: no serial clock movement while the converter works
  a_r3_quiet_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |=> $stable(sclkLevel));

  // R4: first bit is taken with the clock still at rest
  a_r4_msb_before_edge: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MSB) |-> (sclkLevel == idleHigh));

  // R5: sixteen toggles bring the clock back to its rest level
  a_r5_returns_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |-> (sclkLevel == idleHigh));

  // R6: exactly the full byte has been collected at completion
  a_r6_bit_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |-> (bitCnt == BIT_W'(DATA_BITS)));

  // R10: a request while busy does not restart the pulse
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && (state != ST_CONV)) |=> !$rose(convLow));

endmodule

// File: rtl/adc_rd_data.sv
module adc_rd_data
  import adc_rd_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdStrobe_t            strb,
  input  logic                 idleHigh,
  input  logic                 sdataIn,
  output logic                 sclkOut,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 doneOut
);

  logic                 sclkQ;
  logic [DATA_BITS-1:0] shiftQ;
  logic [DATA_BITS-1:0] dataQ;
  logic                 doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= idleHigh;
      shiftQ <= '0;
      dataQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.publish;
      if (strb.toggle) sclkQ <= ~sclkQ;
      else if (strb.park) sclkQ <= idleHigh;
      // First bit lands in the LSB and is pushed up to the MSB by later shifts
      if (strb.loadMsb) shiftQ <= {{(DATA_BITS-1){1'b0}}, sdataIn};
      else if (strb.shiftBit) shiftQ <= {shiftQ[DATA_BITS-2:0], sdataIn};
      if (strb.publish) dataQ <= shiftQ;
    end
  end

  assign sclkOut = sclkQ;
  assign dataOut = dataQ;
  assign doneOut = doneQ;

  // R9: the completion strobe never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R6: no bit is appended while the serial clock is parked
  a_r6_no_shift_parked: assert property (@(posedge clk) disable iff (!rstN)
    strb.park |-> !strb.shiftBit);

endmodule

// File: rtl/adc_rd_top.sv
module adc_rd_top
  import adc_rd_pkg::*;
#(
  parameter int CONV_CYCLES = 940,
  parameter int START_PULSE = 4,
  parameter int HALF_CYCLES = 13,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 idleHigh,
  input  logic                 sdataIn,
  output logic                 convStN,
  output logic                 sclkOut,
  output logic                 busy,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 doneOut
);

  rdStrobe_t strb;

  adc_rd_ctrl #(
    .CONV_CYCLES(CONV_CYCLES),
    .START_PULSE(START_PULSE),
    .HALF_CYCLES(HALF_CYCLES),
    .DATA_BITS  (DATA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .idleHigh (idleHigh),
    .sclkLevel(sclkOut),
    .strb     (strb),
    .convStN  (convStN),
    .busy     (busy)
  );

  adc_rd_data #(
    .DATA_BITS(DATA_BITS)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .idleHigh(idleHigh),
    .sdataIn (sdataIn),
    .sclkOut (sclkOut),
    .dataOut (dataOut),
    .doneOut (doneOut)
  );

endmodule

// File: tb/sim_adc_rd_top.sv
`timescale 1ns/1ps
module sim_adc_rd_top;

  localparam int C      = 940;
  localparam int P      = 4;
  localparam int H      = 13;
  localparam int NB     = 8;
  localparam int DONE_T = C + 2 + 2 * NB * H;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       idleHigh = 1'b0;
  logic       sdataIn = 1'b0;
  logic       convStN;
  logic       sclkOut;
  logic       busy;
  logic [7:0] dataOut;
  logic       doneOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference state: cycles since acceptance, -1 when idle
  int         tm = -1;
  logic       idleQ = 1'b0;
  logic [7:0] expData = 8'h00;
  logic [7:0] adcVal = 8'h00;
  logic [7:0] devVal = 8'h00;
  bit         armed = 0;

  always #4 clk = ~clk;

  adc_rd_top u0 (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .idleHigh(idleHigh),
    .sdataIn (sdataIn),
    .convStN (convStN),
    .sclkOut (sclkOut),
    .busy    (busy),
    .dataOut (dataOut),
    .doneOut (doneOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural timeline of a transaction
  always @(posedge clk) begin
    if (!rstN) begin
      tm = -1;
      expData = 8'h00;
      armed = 0;
    end else begin
      if (tm < 0 || tm == DONE_T) tm = startReq ? 0 : -1;
      else tm = tm + 1;
      if (tm == DONE_T) expData = devVal;
      armed = 1;
    end
    idleQ = idleHigh;
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && armed) begin
      int   tog;
      logic expSclk;
      tog = 0;
      if (tm >= C + 1) tog = (tm - C - 1) / H;
      if (tog > 16) tog = 16;
      expSclk = idleQ ^ logic'(tog % 2);
      if (tm < 0) begin
        check("R2 convStN idle", int'(convStN), 1);
        check("R2 busy idle", int'(busy), 0);
        check("R8 sclk rest", int'(sclkOut), int'(idleQ));
        check("R9 done idle", int'(doneOut), 0);
      end else begin
        check("R2 convStN pulse", int'(convStN), (tm < P) ? 0 : 1);
        check("R2 R9 busy", int'(busy), (tm < DONE_T) ? 1 : 0);
        if (tm <= C + 1) check("R3 sclk quiet", int'(sclkOut), int'(idleQ));
        else check("R5 R8 sclk toggles", int'(sclkOut), int'(expSclk));
        check("R9 done timing", int'(doneOut), (tm == DONE_T) ? 1 : 0);
      end
      check("R7 R9 dataOut hold", int'(dataOut), int'(expData));
    end
  end

  // Converter model: low during conversion, changes data on falling edges
  initial begin
    forever begin
      int idx;
      int rises;
      @(negedge convStN);
      devVal = adcVal;
      sdataIn = 1'b0;
      repeat (C - 2) @(posedge clk);
      #1 sdataIn = devVal[7];
      idx = 7;
      rises = 0;
      while (rises < 8) begin
        @(sclkOut);
        if (sclkOut) rises++;
        else if (idx > 0) begin
          idx--;
          sdataIn = devVal[idx];
        end
      end
      sdataIn = ~devVal[0];  // released line reads as a wrong bit
    end
  end

  task automatic waitResult(input logic [7:0] val, input string tag);
    bit got;
    got = 0;
    for (int i = 0; i < DONE_T + 4 && !got; i++) begin
      @(negedge clk);
      if (doneOut) got = 1;
    end
    check({tag, " R9 done seen"}, int'(got), 1);
    if (got) check({tag, " R4 R6 R7 result"}, int'(dataOut), int'(val));
  endtask

  task automatic runTxn(input logic [7:0] val);
    adcVal = val;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitResult(val, "txn");
    @(negedge clk);
  endtask

  // Requests during wait, during clocking and in the final busy cycle
  task automatic interfereTxn(input logic [7:0] val);
    adcVal = val;
    startReq = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= DONE_T + 6; k++) begin
      startReq = (k == 6 || k == C + 40 || k == DONE_T);
      @(negedge clk);
      if (k == DONE_T) begin
        check("R10 done kept", int'(doneOut), 1);
        check("R10 result kept", int'(dataOut), int'(val));
      end
    end
    startReq = 1'b0;
    check("R10 no restart convStN", int'(convStN), 1);
    check("R10 no restart busy", int'(busy), 0);
  endtask

  // Request held across completion starts the next transaction at once
  task automatic backToBack(input logic [7:0] val);
    adcVal = val;
    startReq = 1'b1;
    repeat (DONE_T + 1) @(negedge clk);
    check("R9 first done", int'(doneOut), 1);
    check("R7 first result", int'(dataOut), int'(val));
    @(negedge clk);
    startReq = 1'b0;
    check("R2 restart busy", int'(busy), 1);
    check("R2 restart convStN", int'(convStN), 0);
    waitResult(val, "second");
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values
    check("R1 convStN reset", int'(convStN), 1);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(doneOut), 0);
    check("R1 dataOut reset", int'(dataOut), 0);
    check("R1 sclk reset", int'(sclkOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runTxn(8'h00);
    runTxn(8'hFF);
    runTxn(8'hA5);
    runTxn(8'h5A);
    runTxn(8'h80);
    runTxn(8'h01);

    idleHigh = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 rest high", int'(sclkOut), 1);
    runTxn(8'h3C);
    runTxn(8'hFF);
    runTxn(8'h00);
    runTxn(8'h96);
    interfereTxn(8'hC3);

    idleHigh = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 rest low", int'(sclkOut), 0);
    backToBack(8'h7E);
    interfereTxn(8'h24);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule